// File: doc/BRIEF.md
# Unpacked BCD Subtraction Adjust Unit

This block is one slice of an integer execution unit. It applies the decimal correction that follows a binary subtraction of one unpacked BCD digit from another. The subtraction leaves its byte result in the low half of a 16-bit accumulator. When the issue logic presents the adjust opcode with a strobe, the unit reads the accumulator and the incoming auxiliary-carry flag. It then produces the corrected accumulator, the decimal-borrow flags and a deterministic set of the remaining arithmetic flags.

The instruction is illegal in two cases: while the core runs in 64-bit mode, and whenever a lock prefix is attached. In either case the unit raises an invalid-opcode exception instead of a result. All outputs are registered, so a result or an exception appears one clock after the strobe.

Top module: `bcd_sub_adjust`

## Requirements
- R1: A strobe (`op_valid`=1) carrying opcode 0x3F, with `long_mode`=0 and `lock_pfx`=0, produces exactly one `res_valid` pulse in the following cycle, with `ud_exc`=0.
- R2: A strobe with any opcode other than 0x3F produces neither `res_valid` nor `ud_exc`, and every data and flag output keeps its previous value.
- R3: Correction applies when the low four bits of the accumulator are greater than 9, or when `aux_in`=1.
- R4: When correction applies, the result is the full 16-bit accumulator minus 6, with its high byte then lowered by 1 (a low byte below 6 therefore lowers the high byte by 2 in total), and both `carry_out` and `aux_out` are 1.
- R5: When correction does not apply, `carry_out` and `aux_out` are 0 and the high byte of `acc_out` equals the high byte of `acc_in`.
- R6: Bits 7..4 of `acc_out` are 0 after every accepted operation.
- R7: A 0x3F strobe with `long_mode`=1 raises `ud_exc` for one cycle in the following cycle, with no `res_valid`, and the accumulator and flag outputs keep their previous values.
- R8: A 0x3F strobe with `lock_pfx`=1 raises `ud_exc` in the same way as R7, whatever the value of `long_mode`.
- R9: On a result, `zero_out` is 1 when `acc_out[7:0]` is 0, `sign_out` equals `acc_out[7]`, `parity_out` is 1 when `acc_out[7:0]` has an even number of set bits, and `ovf_out` is 0.
- R10: A synchronous active-high `rst` clears `res_valid`, `ud_exc`, `acc_out` and all flag outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 8 | Opcode byte of the strobed operation |
| acc_in | input | 16 | Accumulator value before adjustment |
| aux_in | input | 1 | Incoming auxiliary-carry flag |
| long_mode | input | 1 | Core runs in 64-bit mode |
| lock_pfx | input | 1 | Lock prefix attached to the operation |
| res_valid | output | 1 | Result pulse, one cycle after an accepted strobe |
| acc_out | output | 16 | Corrected accumulator |
| carry_out | output | 1 | Carry flag (decimal borrow) |
| aux_out | output | 1 | Auxiliary-carry flag (decimal borrow) |
| ovf_out | output | 1 | Overflow flag, always 0 |
| sign_out | output | 1 | Sign flag of the final low byte |
| zero_out | output | 1 | Zero flag of the final low byte |
| parity_out | output | 1 | Even parity of the final low byte |
| ud_exc | output | 1 | Invalid-opcode exception pulse |

## Verification
On every cycle the assertions check the following. Results and exceptions are never both asserted. Each one follows a strobe in the previous cycle. On a result, the two borrow flags agree, the top nibble of the low byte is clear, the derived flags match the low byte, and the registered outputs hold still across an exception or a rejected opcode. The arithmetic itself can only be shown by the bench's sweeps. Those sweeps cover all 65536 accumulator values with the auxiliary flag set and clear, the borrow of 6 across the byte boundary, the foreign opcodes, and the mode and lock combinations.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int unsigned ACC_W   = 16;
    localparam int unsigned BYTE_W  = ACC_W / 2;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned OPC_W   = 8;

    localparam logic [OPC_W-1:0]  OPC_ADJ     = 8'h3F;
    localparam logic [NIB_W-1:0]  NIB_MAX_DEC = 4'd9;
    localparam logic [ACC_W-1:0]  DEC_FIX     = 16'd6;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             cf;
        logic             af;
    } adj_res_t;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic par;
    } aux_flags_t;

    typedef enum logic [1:0] {
        ISS_IDLE  = 2'd0,
        ISS_EXEC  = 2'd1,
        ISS_FAULT = 2'd2
    } issue_kind_t;

    function automatic logic needs_fix(input logic [NIB_W-1:0] nib, input logic af);
        return (nib > NIB_MAX_DEC) || af;
    endfunction

    function automatic logic even_par(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/bcd_adj_decode.sv
module bcd_adj_decode
    import bcd_adj_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic             long_mode,
    input  logic             lock_pfx,
    output issue_kind_t      kind
);
    logic hit;
    logic illegal;

    assign hit     = op_valid && (op_code == OPC_ADJ);
    assign illegal = long_mode || lock_pfx;

    always_comb begin
        kind = ISS_IDLE;
        if (hit) begin
            kind = illegal ? ISS_FAULT : ISS_EXEC;
        end
    end
endmodule

// File: rtl/bcd_adj_core.sv
module bcd_adj_core
    import bcd_adj_pkg::*;
(
    input  logic [ACC_W-1:0] acc_in,
    input  logic             aux_in,
    output adj_res_t         res
);
    logic              fix;
    logic [ACC_W-1:0]  less6;
    logic [BYTE_W-1:0] hi_fixed;
    logic [BYTE_W-1:0] hi_sel;
    logic [NIB_W-1:0]  lo_sel;

    assign fix      = needs_fix(acc_in[NIB_W-1:0], aux_in);
    assign less6    = acc_in - DEC_FIX;
    assign hi_fixed = less6[ACC_W-1:BYTE_W] - {{(BYTE_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (fix) begin
            hi_sel = hi_fixed;
            lo_sel = less6[NIB_W-1:0];
        end else begin
            hi_sel = acc_in[ACC_W-1:BYTE_W];
            lo_sel = acc_in[NIB_W-1:0];
        end
        res.acc = {hi_sel, {(BYTE_W-NIB_W){1'b0}}, lo_sel};
        res.cf  = fix;
        res.af  = fix;
    end
endmodule

// File: rtl/bcd_adj_flags.sv
module bcd_adj_flags
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_byte,
    output aux_flags_t        flg
);
    always_comb begin
        flg.ovf  = 1'b0;
        flg.sign = lo_byte[BYTE_W-1];
        flg.zero = (lo_byte == '0);
        flg.par  = even_par(lo_byte);
    end
endmodule

// File: rtl/bcd_sub_adjust.sv
module bcd_sub_adjust
    import bcd_adj_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [7:0]  op_code,
    input  logic [15:0] acc_in,
    input  logic        aux_in,
    input  logic        long_mode,
    input  logic        lock_pfx,
    output logic        res_valid,
    output logic [15:0] acc_out,
    output logic        carry_out,
    output logic        aux_out,
    output logic        ovf_out,
    output logic        sign_out,
    output logic        zero_out,
    output logic        parity_out,
    output logic        ud_exc
);
    issue_kind_t kind;
    adj_res_t    nxt_res;
    aux_flags_t  nxt_flg;
    adj_res_t    res_q;
    aux_flags_t  flg_q;

    bcd_adj_decode u_dec (
        .op_valid  (op_valid),
        .op_code   (op_code),
        .long_mode (long_mode),
        .lock_pfx  (lock_pfx),
        .kind      (kind)
    );

    bcd_adj_core u_core (
        .acc_in (acc_in),
        .aux_in (aux_in),
        .res    (nxt_res)
    );

    bcd_adj_flags u_flg (
        .lo_byte (nxt_res.acc[BYTE_W-1:0]),
        .flg     (nxt_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            ud_exc    <= 1'b0;
            res_q     <= '0;
            flg_q     <= '0;
        end else begin
            res_valid <= (kind == ISS_EXEC);
            ud_exc    <= (kind == ISS_FAULT);
            if (kind == ISS_EXEC) begin
                res_q <= nxt_res;
                flg_q <= nxt_flg;
            end
        end
    end

    assign acc_out    = res_q.acc;
    assign carry_out  = res_q.cf;
    assign aux_out    = res_q.af;
    assign ovf_out    = flg_q.ovf;
    assign sign_out   = flg_q.sign;
    assign zero_out   = flg_q.zero;
    assign parity_out = flg_q.par;

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && ud_exc));

    // R1
    res_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(op_valid));

    // R8
    exc_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ud_exc |-> $past(op_valid) && ($past(long_mode) || $past(lock_pfx)));

    // R4
    flags_agree_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (carry_out == aux_out));

    // R6
    top_nib_clear_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (acc_out[7:4] == 4'h0));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (zero_out == (acc_out[7:0] == 8'h00)) && !ovf_out);

    // R5
    no_fix_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !carry_out) |-> (acc_out[15:8] == $past(acc_in[15:8])));

    // R7
    hold_on_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(rst)) |-> $stable(acc_out) && $stable(carry_out));

endmodule

// File: tb/bcd_sub_adjust_bench.sv
module bcd_sub_adjust_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [15:0] acc_in;
    logic        aux_in;
    logic        long_mode;
    logic        lock_pfx;
    logic        res_valid;
    logic [15:0] acc_out;
    logic        carry_out, aux_out, ovf_out, sign_out, zero_out, parity_out, ud_exc;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] e_acc;
    logic        e_cf;

    always #5 clk = ~clk;

    bcd_sub_adjust u_bcd_sub_adjust (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .aux_in(aux_in), .long_mode(long_mode), .lock_pfx(lock_pfx),
        .res_valid(res_valid), .acc_out(acc_out), .carry_out(carry_out),
        .aux_out(aux_out), .ovf_out(ovf_out), .sign_out(sign_out),
        .zero_out(zero_out), .parity_out(parity_out), .ud_exc(ud_exc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic model of R3..R5
    task automatic model(input int acc, input bit aux);
        int lo, v, hi;
        bit fix;
        lo  = acc % 16;
        fix = (lo > 9) || aux;
        if (fix) begin
            v  = (acc + 65536 - 6) % 65536;
            hi = ((v / 256) + 255) % 256;
            lo = v % 16;
        end else begin
            hi = acc / 256;
        end
        e_acc = 16'(hi * 256 + lo);
        e_cf  = fix;
    endtask

    task automatic issue(input logic [7:0] code, input logic [15:0] a, input logic ax,
                         input logic lm, input logic lk);
        op_valid  = 1'b1;
        op_code   = code;
        acc_in    = a;
        aux_in    = ax;
        long_mode = lm;
        lock_pfx  = lk;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic check_result(input string req);
        int ones;
        ones = $countones(e_acc[7:0]);
        check({req, " res_valid"}, {31'd0, res_valid}, 32'd1);
        check({req, " ud_exc"}, {31'd0, ud_exc}, 32'd0);
        check({req, " acc R4/R5/R6"}, {16'd0, acc_out}, {16'd0, e_acc});
        check({req, " flags R4/R5"}, {30'd0, carry_out, aux_out}, {30'd0, e_cf, e_cf});
        check({req, " R9 flags"}, {28'd0, ovf_out, sign_out, zero_out, parity_out},
              {28'd0, 1'b0, e_acc[7], e_acc[7:0] == 8'h00, (ones % 2) == 0});
    endtask

    task automatic check_hold(input string req, input logic exc);
        check({req, " res_valid"}, {31'd0, res_valid}, 32'd0);
        check({req, " ud_exc"}, {31'd0, ud_exc}, {31'd0, exc});
        check({req, " acc hold"}, {16'd0, acc_out}, {16'd0, e_acc});
        check({req, " flag hold"}, {30'd0, carry_out, aux_out}, {30'd0, e_cf, e_cf});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = 8'h00; acc_in = 16'h0000;
        aux_in = 1'b0; long_mode = 1'b0; lock_pfx = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 outputs", {res_valid, ud_exc, acc_out, carry_out, aux_out,
              ovf_out, sign_out, zero_out, parity_out}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4 R5 R6 R9: exhaustive sweep, aux clear and set
        for (int ax = 0; ax < 2; ax++) begin
            for (int a = 0; a < 65536; a++) begin
                issue(8'h3F, 16'(a), 1'(ax), 1'b0, 1'b0);
                model(a, 1'(ax));
                check_result("R1 sweep");
            end
        end

        // R4 corner: low byte below 6 lowers high byte by 2
        issue(8'h3F, 16'h0503, 1'b1, 1'b0, 1'b0);
        check("R4 double borrow", {16'd0, acc_out}, {16'd0, 16'h030D});

        // R1: single pulse only
        @(negedge clk);
        check("R1 single pulse", {31'd0, res_valid}, 32'd0);
        model(16'h0503, 1'b1);

        // R2: foreign opcodes, with R3-triggering data
        for (int c = 0; c < 256; c++) begin
            if (c != 8'h3F) begin
                issue(8'(c), 16'h12FF, 1'b1, 1'b0, 1'b0);
                check_hold("R2 foreign opcode", 1'b0);
            end
        end

        // R7: 64-bit mode faults
        issue(8'h3F, 16'h00AB, 1'b1, 1'b1, 1'b0);
        check_hold("R7 long mode", 1'b1);
        @(negedge clk);
        check("R7 exc single pulse", {31'd0, ud_exc}, 32'd0);

        // R8: lock prefix, both modes
        issue(8'h3F, 16'h0777, 1'b0, 1'b0, 1'b1);
        check_hold("R8 lock legacy", 1'b1);
        issue(8'h3F, 16'h0777, 1'b0, 1'b1, 1'b1);
        check_hold("R8 lock long", 1'b1);

        // R2: foreign opcode with fault inputs raises nothing
        issue(8'h40, 16'h0777, 1'b0, 1'b1, 1'b1);
        check_hold("R2 foreign faulty", 1'b0);

        // R1 after faults, then R10 reset mid-run
        issue(8'h3F, 16'h0109, 1'b0, 1'b0, 1'b0);
        model(16'h0109, 1'b0);
        check_result("R1 after fault");
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset after use", {res_valid, ud_exc, acc_out, carry_out, aux_out,
              ovf_out, sign_out, zero_out, parity_out}, 32'd0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule